// File: doc/BRIEF.md
# Shared Bus Arbiter With Grant Parking

This block decides which of several masters may own a shared bus. Each master has its own active-low request input and gets its own active-low grant output. The bus has one shared active-low busy line. The current owner pulls it low while it uses the bus. The arbiter works out the next owner while the present owner is still transferring, so a handover costs little time. When no other master is asking, the grant stays on the last owner. That owner can then start further transfers without arbitrating again.

The controller has two states. In `ST_OWN` exactly one grant is driven. In `ST_RELEASE` every grant is withdrawn and the arbiter waits for the busy line to come back high.

- **Transition T_REVOKE (`ST_OWN` to `ST_RELEASE`)** is taken when a master that does not hold the grant is sampled requesting.
- **Transition T_HANDOVER (`ST_RELEASE` to `ST_OWN`)** is taken on the first edge at which busy is sampled high. The new owner is chosen round-robin, starting from the master after the previous owner. If nobody is requesting at that edge, the grant returns to the previous owner.

An owner in the middle of an indivisible sequence can keep busy low after losing its grant. No new grant is given until it lets go. The number of masters is a parameter from 2 to 8.

Top module: `bus_park_arbiter`

## Requirements
- R1: While `rst_n` is low all bits of `gnt_n` are high. After reset is released with no requests, master 0 holds the grant (`gnt_n` bit 0 low) immediately.
- R2: At most one bit of `gnt_n` is low at any time.
- R3: While a grant is held and no master other than the owner is sampled requesting, the grant stays unchanged. This holds whether or not the owner requests or drives busy.
- R4: When a grant is held and some master without the grant is sampled with its `req_n` low at a rising edge, all grants are high from that edge on.
- R5: Once grants are withdrawn, no grant is driven while `busy_n` is sampled low. The new grant appears right after the first rising edge at which `busy_n` is sampled high.
- R6: At handover the new owner is the first requesting master in the order owner+1, owner+2, and so on, wrapping modulo the master count. The previous owner comes last in that order.
- R7: If no master is requesting at the handover edge, the grant returns to the previous owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | NUM_MASTERS | Per-master bus request, active low, bit i is master i |
| busy_n | input | 1 | Shared bus busy/acknowledge line, active low |
| gnt_n | output | NUM_MASTERS | Per-master bus grant, active low, bit i is master i |

## Verification
The assertions assume the following about the inputs:
- The shared busy line is high during reset and in the cycle reset is released, because no master may own the bus then.
- `req_n` and `busy_n` change only away from the rising edge.

The stimulus drives every input on the falling edge. It keeps busy high through reset and drives busy low only from a master that has held the grant. This includes the long hold after a revoke, which mimics an indivisible sequence.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic {
        ST_OWN     = 1'b0,
        ST_RELEASE = 1'b1
    } arb_state_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int NUM = 4,
    parameter int IW  = $clog2(NUM)
) (
    input  logic [NUM-1:0] want,
    input  logic [IW-1:0]  last,
    output logic           hit,
    output logic [IW-1:0]  pick
);
    // search starts right after the previous owner; the previous owner is visited last
    always_comb begin
        hit  = 1'b0;
        pick = last;
        for (int k = 1; k <= NUM; k++) begin
            int cand;
            cand = (int'(last) + k) % NUM;
            if (!hit && want[cand]) begin
                hit  = 1'b1;
                pick = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/arb_grant_drv.sv
module arb_grant_drv #(
    parameter int NUM = 4,
    parameter int IW  = $clog2(NUM)
) (
    input  logic           en,
    input  logic [IW-1:0]  owner,
    output logic [NUM-1:0] gnt_n
);
    for (genvar i = 0; i < NUM; i++) begin : g_line
        assign gnt_n[i] = ~(en && (owner == IW'(i)));
    end
endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter #(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_n,
    input  logic                   busy_n,
    output logic [NUM_MASTERS-1:0] gnt_n
);
    import arb_pkg::*;

    localparam int IW = $clog2(NUM_MASTERS);

    arb_state_e          state, state_nx;
    logic [IW-1:0]       owner, owner_nx;
    logic [NUM_MASTERS-1:0] want, own_mask, rivals;
    logic                rr_hit;
    logic [IW-1:0]       rr_pick;

    assign want = ~req_n;

    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_mask
        assign own_mask[i] = (owner == IW'(i));
    end
    assign rivals = want & ~own_mask;

    arb_rr_pick #(.NUM(NUM_MASTERS), .IW(IW)) u_pick (
        .want (want),
        .last (owner),
        .hit  (rr_hit),
        .pick (rr_pick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OWN;
            owner <= '0;
        end else begin
            state <= state_nx;
            owner <= owner_nx;
        end
    end

    // transitions: T_REVOKE and T_HANDOVER
    always_comb begin
        state_nx = state;
        owner_nx = owner;
        unique case (state)
            ST_OWN: begin
                if (|rivals) state_nx = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (busy_n) begin
                    state_nx = ST_OWN;
                    if (rr_hit) owner_nx = rr_pick;
                end
            end
            default: state_nx = ST_RELEASE;
        endcase
    end

    // outputs
    arb_grant_drv #(.NUM(NUM_MASTERS), .IW(IW)) u_drv (
        .en    (rst_n && (state == ST_OWN)),
        .owner (owner),
        .gnt_n (gnt_n)
    );

    // R1: no grant during reset
    always_comb begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (&gnt_n);
        end
    end

    // R2: never two grants
    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gnt_n));

    // R3: parked grant holds while nobody else asks
    p_park_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&gnt_n) && !(|(~req_n & gnt_n))) |=> $stable(gnt_n));

    // R4: rival request withdraws the grant after the sampling edge
    p_revoke_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&gnt_n) && (|(~req_n & gnt_n))) |=> (&gnt_n));

    // R5: a grant only reappears after busy was seen released
    p_grant_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&gnt_n) && $past(&gnt_n)) |-> $past(busy_n));
endmodule

// File: tb/bus_park_arbiter_test.sv
`timescale 1ns/1ps
module bus_park_arbiter_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] req_n;
    logic         busy_n;
    logic [N-1:0] gnt_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];

    always #5 clk = ~clk;

    bus_park_arbiter #(.NUM_MASTERS(N)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_n  (req_n),
        .busy_n (busy_n),
        .gnt_n  (gnt_n)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: gnt_n=%b expected %b", tag, act, exp);
        end
    endtask

    // driver: apply inputs on the falling edge, expectation is gnt_n after the next rising edge
    task automatic step(input logic [N-1:0] r, input logic b, input logic [N-1:0] e, input string tag);
        @(negedge clk);
        req_n  = r;
        busy_n = b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [N-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, gnt_n, e);
                checks++;
                if ($countones(~gnt_n) > 1) begin
                    fails++;
                    $display("FAIL R2: gnt_n=%b expected at most one low bit", gnt_n);
                end
            end
        end
    end

    initial begin
        rst_n  = 1'b0;
        req_n  = '1;
        busy_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", gnt_n, 4'b1111);
        rst_n = 1'b1;
        #1;
        check("R1 park on master 0", gnt_n, 4'b1110);
        step(4'b1111, 1'b1, 4'b1110, "R1 idle park");
        step(4'b1111, 1'b1, 4'b1110, "R3 park hold");
        step(4'b1110, 1'b1, 4'b1110, "R3 owner request");
        step(4'b1110, 1'b0, 4'b1110, "R3 owner busy");
        step(4'b1010, 1'b0, 4'b1111, "R4 revoke for master 2");
        step(4'b1010, 1'b0, 4'b1111, "R5 locked hold");
        step(4'b1010, 1'b0, 4'b1111, "R5 locked hold");
        step(4'b1010, 1'b1, 4'b1011, "R6 handover to 2");
        step(4'b0001, 1'b0, 4'b1111, "R4 revoke from 2");
        step(4'b0001, 1'b0, 4'b1111, "R5 wait busy");
        step(4'b0001, 1'b1, 4'b0111, "R6 handover to 3");
        step(4'b1001, 1'b0, 4'b1111, "R4 revoke from 3");
        step(4'b1001, 1'b1, 4'b1101, "R6 wrap to 1");
        step(4'b1111, 1'b1, 4'b1101, "R3 park on 1");
        step(4'b0111, 1'b1, 4'b1111, "R4 pulse from 3");
        step(4'b1111, 1'b1, 4'b1101, "R7 return to 1");
        step(4'b1011, 1'b1, 4'b1111, "R4 revoke for 2");
        step(4'b1101, 1'b1, 4'b1101, "R6 previous owner last");
        step(4'b1111, 1'b1, 4'b1101, "R3 final park");
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule